// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Responder

This block is the slave side of a two-wire serial EEPROM. A processor does not have a real serial controller here. Instead it writes new clock and data line levels through a register, one update at a time. The block receives each such update as a one-cycle strobe that carries the new SCL and SDA levels. After every update it returns the SDA level that the slave drives back, and the processor reads that level as bit 0 of a status word. The memory behind the slave is a 256-byte read-only image with fixed contents.

The protocol is counted in bit ticks and is simpler than the full two-wire protocol. A start condition arms the slave. It then shifts in an 8-bit command whose last bit selects read or write, and acknowledges. Next it shifts in an 8-bit word address. During the address bits of a read, it drives out, most significant bit first, the byte that the previous transaction fetched. When the last address bit arrives it fetches the addressed byte and acknowledges again, then goes idle until the next start. Between starts, every update is ignored. The update strobe is accepted in every cycle and has no back-pressure, because a register write cannot be stalled.

Top module: `sbe_responder`

## Requirements
- R1: Synchronous active-high reset clears the transaction state and sets both stored line levels to 1. While reset is held and in the cycle after it, `sda_out` is 1.
- R2: An update that keeps SCL high while SDA falls from 1 to 0 starts a transaction. The tick count becomes 1 and the command is cleared, even in the middle of a previous transaction.
- R3: An update that keeps SCL high while SDA rises from 0 to 1 is a stop and leaves the tick count as it is. A transaction that was in progress continues bit for bit.
- R4: With no transaction in progress and no acknowledge pending, every update other than a start has no effect on the state, and `sda_out` simply echoes the written SDA.
- R5: A bit is taken only on an update where SCL rises from 0 to 1 and SDA equals its previously stored level. A rising update that also changes SDA takes no bit.
- R6: Eight taken bits form the command, first bit in the most significant position. Command bit 0 equal to 1 selects read and 0 selects write. After the eighth bit an acknowledge is pending.
- R7: When an acknowledge is pending, the next rising SCL update drives `sda_out` to 0, whatever SDA was written, clears the pending flag and consumes no bit.
- R8: The next eight taken bits form the word address, most significant bit first. In a read, each of these rising updates drives the current top bit of the data byte, which then shifts left. In a write, `sda_out` echoes the written SDA.
- R9: The eighth address bit loads the addressed byte into the data register, sets an acknowledge pending and returns the tick count to 0. After that acknowledge, the block is idle.
- R10: The memory image holds 0x80 at address 0, 0x08 at address 1 and 0x04 at address 2. Every other address a holds (7*a + 3) mod 256.
- R11: Without an update strobe, `sda_out` holds its value.
- R12: `sda_out` shows the result of an update in the clock cycle after the strobe: the driven level if the slave drives, otherwise the written SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | One-cycle strobe: a new pair of line levels is written |
| upd_scl | input | 1 | Written clock line level |
| upd_sda | input | 1 | Written data line level |
| sda_out | output | 1 | Data line level as driven back by the slave |

## Verification
The bound checker watches several behaviours in every cycle. It checks the reset values, that a start loads tick 1, that a stop leaves the tick unchanged, and that updates are ignored while idle. It also checks the forced-low acknowledge, that a rising update which changes SDA takes no bit, that the fetch returns the tick to 0 with an acknowledge pending, and that the output holds between strobes. Other behaviours can only be shown by the bench's transactions, because they depend on whole sequences of updates. These are the byte that a read shifts out coming from the previous fetch, the contents of the memory image, a stop or a glitch in the middle of a command shifting the acknowledge by the expected number of clocks, and a restart resetting the command count.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  // Classification of one line update, relative to the stored levels
  typedef struct packed {
    logic start;   // SCL held high, SDA falls
    logic rise;    // SCL goes 0 -> 1
    logic steady;  // written SDA equals stored SDA
  } line_ev_t;
endpackage

// File: rtl/sbe_line_monitor.sv
module sbe_line_monitor
  import sbe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     upd_valid,
  input  logic     upd_scl,
  input  logic     upd_sda,
  input  logic     drv_force,
  input  logic     drv_level,
  output line_ev_t ev,
  output logic     scl_q,
  output logic     sda_q
);
  always_comb begin
    ev.start  = upd_valid && scl_q && upd_scl && sda_q && !upd_sda;
    ev.rise   = upd_valid && !scl_q && upd_scl;
    ev.steady = (sda_q == upd_sda);
  end

  // Stored levels: the written SCL, and SDA as the slave leaves it
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else if (upd_valid) begin
      scl_q <= upd_scl;
      sda_q <= drv_force ? drv_level : upd_sda;
    end
  end
endmodule

// File: rtl/sbe_image_rom.sv
module sbe_image_rom #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  // Fixed image: three leading bytes, then a computed fill
  function automatic logic [DW-1:0] image_byte(input logic [AW-1:0] a);
    int v;
    case (int'(a))
      0:       image_byte = DW'(8'h80);
      1:       image_byte = DW'(8'h08);
      2:       image_byte = DW'(8'h04);
      default: begin
        v = int'(a) * 7 + 3;
        image_byte = DW'(v);
      end
    endcase
  endfunction

  always_comb rd_data = image_byte(rd_addr);
endmodule

// File: rtl/sbe_sequencer.sv
module sbe_sequencer
  import sbe_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  line_ev_t      ev,
  input  logic          bit_in,
  input  logic [DW-1:0] rom_data,
  output logic [AW-1:0] rom_addr,
  output logic          drv_force,
  output logic          drv_level,
  output logic [TW-1:0] tick,
  output logic          ack
);
  localparam logic [TW-1:0] K_START    = TW'(1);
  localparam logic [TW-1:0] K_CMD_END  = TW'(CW + 1);
  localparam logic [TW-1:0] K_ADDR_END = TW'(CW + AW + 1);

  logic [CW-1:0] cmd;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic          idle;
  logic          active_rise;
  logic [TW-1:0] tick_inc;
  logic [AW-1:0] addr_next;

  always_comb begin
    idle        = (tick == '0) && !ack;
    active_rise = ev.rise && !idle;
    tick_inc    = tick + TW'(1);
    addr_next   = {addr[AW-2:0], bit_in};
    rom_addr    = addr_next;
  end

  // What the slave drives on this update
  always_comb begin
    drv_force = 1'b0;
    drv_level = 1'b0;
    if (active_rise) begin
      if (ack) begin
        drv_force = 1'b1;
      end else if (ev.steady) begin
        if (tick >= K_CMD_END && tick < K_ADDR_END) begin
          if (cmd[0]) begin
            drv_force = 1'b1;
            drv_level = data[DW-1];
          end
        end else if (tick >= K_ADDR_END) begin
          drv_force = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick <= '0;
      cmd  <= '0;
      addr <= '0;
      data <= '0;
      ack  <= 1'b0;
    end else if (ev.start) begin
      tick <= K_START;
      cmd  <= '0;
    end else if (active_rise) begin
      if (ack) begin
        ack <= 1'b0;
      end else if (ev.steady) begin
        if (tick < K_CMD_END) begin
          cmd  <= {cmd[CW-2:0], bit_in};
          tick <= tick_inc;
          if (tick_inc == K_CMD_END) ack <= 1'b1;
        end else if (tick < K_ADDR_END) begin
          addr <= addr_next;
          if (tick_inc == K_ADDR_END) begin
            data <= rom_data;
            ack  <= 1'b1;
            tick <= '0;
          end else begin
            data <= data << 1;
            tick <= tick_inc;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sbe_responder.sv
module sbe_responder
  import sbe_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int ADDR_BITS = 8,
  parameter int DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_valid,
  input  logic upd_scl,
  input  logic upd_sda,
  output logic sda_out
);
  localparam int TICK_W = $clog2(CMD_BITS + ADDR_BITS + 2);

  line_ev_t             ev;
  logic                 scl_q;
  logic                 sda_q;
  logic                 drv_force;
  logic                 drv_level;
  logic [ADDR_BITS-1:0] rom_addr;
  logic [DATA_BITS-1:0] rom_data;
  logic [TICK_W-1:0]    seq_tick;
  logic                 seq_ack;

  sbe_line_monitor u_line (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .upd_scl   (upd_scl),
    .upd_sda   (upd_sda),
    .drv_force (drv_force),
    .drv_level (drv_level),
    .ev        (ev),
    .scl_q     (scl_q),
    .sda_q     (sda_q)
  );

  sbe_sequencer #(
    .CW (CMD_BITS),
    .AW (ADDR_BITS),
    .DW (DATA_BITS),
    .TW (TICK_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .bit_in    (upd_sda),
    .rom_data  (rom_data),
    .rom_addr  (rom_addr),
    .drv_force (drv_force),
    .drv_level (drv_level),
    .tick      (seq_tick),
    .ack       (seq_ack)
  );

  sbe_image_rom #(
    .AW (ADDR_BITS),
    .DW (DATA_BITS)
  ) u_rom (
    .rd_addr (rom_addr),
    .rd_data (rom_data)
  );

  assign sda_out = sda_q;
endmodule

// File: rtl/sbe_responder_chk.sv
module sbe_responder_chk #(
  parameter int TW       = 5,
  parameter int ADDR_END = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          upd_valid,
  input logic          upd_scl,
  input logic          upd_sda,
  input logic          sda_out,
  input logic          scl_q,
  input logic [TW-1:0] tick,
  input logic          ack
);
  logic is_start, is_stop, is_rise;
  assign is_start = upd_valid && scl_q && upd_scl && sda_out && !upd_sda;
  assign is_stop  = upd_valid && scl_q && upd_scl && !sda_out && upd_sda;
  assign is_rise  = upd_valid && !scl_q && upd_scl;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (tick == '0 && !ack && sda_out));

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    is_start |=> tick == TW'(1));

  p_stop_r3: assert property (@(posedge clk) disable iff (rst)
    is_stop |=> $stable(tick));

  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && tick == '0 && !ack && !is_start)
      |=> (tick == '0 && !ack && sda_out == $past(upd_sda)));

  p_glitch_r5: assert property (@(posedge clk) disable iff (rst)
    (is_rise && !ack && tick != '0 && sda_out != upd_sda) |=> $stable(tick));

  p_ack_low_r7: assert property (@(posedge clk) disable iff (rst)
    (is_rise && ack) |=> (!sda_out && !ack));

  p_fetch_r9: assert property (@(posedge clk) disable iff (rst)
    (is_rise && !ack && tick == TW'(ADDR_END - 1) && sda_out == upd_sda)
      |=> (tick == '0 && ack));

  p_tick_range_r9: assert property (@(posedge clk) disable iff (rst)
    tick < TW'(ADDR_END));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(sda_out));
endmodule

bind sbe_responder sbe_responder_chk #(
  .TW       (TICK_W),
  .ADDR_END (CMD_BITS + ADDR_BITS + 1)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .upd_valid (upd_valid),
  .upd_scl   (upd_scl),
  .upd_sda   (upd_sda),
  .sda_out   (sda_out),
  .scl_q     (scl_q),
  .tick      (seq_tick),
  .ack       (seq_ack)
);

// File: tb/tb_sbe_responder.sv
`timescale 1ns/1ps
module tb_sbe_responder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_valid = 1'b0;
  logic upd_scl = 1'b1;
  logic upd_sda = 1'b1;
  logic sda_out;

  int n_checks = 0;
  int n_errs   = 0;

  always #2.5 clk = ~clk;

  sbe_responder dut (
    .clk       (clk),
    .rst       (rst),
    .upd_valid (upd_valid),
    .upd_scl   (upd_scl),
    .upd_sda   (upd_sda),
    .sda_out   (sda_out)
  );

  // Reference state, kept from the requirements
  bit       m_scl, m_sda, m_ack;
  int       m_tick;
  bit [7:0] m_cmd, m_addr, m_data;

  function automatic bit [7:0] rom_ref(input bit [7:0] a);   // R10
    if (a == 8'd0) return 8'h80;
    if (a == 8'd1) return 8'h08;
    if (a == 8'd2) return 8'h04;
    return 8'((int'(a) * 7 + 3) % 256);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_scl = 1; m_sda = 1; m_ack = 0; m_tick = 0;
    m_cmd = 0; m_addr = 0; m_data = 0;
  endtask

  task automatic model_step(input bit s, input bit d);
    bit dd;
    dd = d;
    if (m_scl && s && (m_sda != d)) begin
      if (!d) begin m_tick = 1; m_cmd = 0; end          // R2 start, R3 stop
    end else if (m_tick == 0 && !m_ack) begin
      // R4 idle
    end else if (!m_scl && s) begin
      if (m_ack) begin
        dd = 0; m_ack = 0;                               // R7
      end else if (m_sda == d) begin                     // R5
        if (m_tick < 9) begin
          m_cmd = {m_cmd[6:0], d}; m_tick++;             // R6
          if (m_tick == 9) m_ack = 1;
        end else if (m_tick < 17) begin
          if (m_cmd[0]) dd = m_data[7];                  // R8
          m_addr = {m_addr[6:0], d}; m_tick++;
          m_data = m_data << 1;
          if (m_tick == 17) begin                        // R9
            m_data = rom_ref(m_addr); m_ack = 1; m_tick = 0;
          end
        end else dd = 0;
      end
    end
    m_scl = s; m_sda = dd;
  endtask

  task automatic upd(input bit s, input bit d, input string tag);
    @(negedge clk);
    chk("R11", {7'd0, sda_out}, {7'd0, m_sda});
    upd_valid = 1; upd_scl = s; upd_sda = d;
    model_step(s, d);
    @(negedge clk);
    upd_valid = 0;
    chk(tag, {7'd0, sda_out}, {7'd0, m_sda});            // R12
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    chk("R1", {7'd0, sda_out}, 8'd1);
    rst = 0; model_reset();
    @(negedge clk);
    chk("R1", {7'd0, sda_out}, 8'd1);
  endtask

  task automatic start_cond();
    upd(1, 1, "R2"); upd(1, 0, "R2");
  endtask

  task automatic send_byte(input bit [7:0] b, input string tag);
    for (int i = 7; i >= 0; i--) begin
      upd(0, b[i], tag); upd(1, b[i], tag);
    end
  endtask

  task automatic ack_clk(input string tag);
    upd(0, 1, tag); upd(1, 1, tag);
    chk(tag, {7'd0, sda_out}, 8'd0);
  endtask

  task automatic txn(input bit rd, input bit [7:0] a, output bit [7:0] seen);
    start_cond();
    send_byte({7'h51, rd}, "R6");
    ack_clk("R7");
    for (int i = 7; i >= 0; i--) begin
      upd(0, a[i], "R8"); upd(1, a[i], "R8");
      seen[i] = sda_out;
    end
    ack_clk("R9");
    upd(0, 1, "R9"); upd(1, 1, "R9");
    chk("R9", {7'd0, sda_out}, 8'd1);                    // idle again: echo
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    bit [7:0] seen;
    bit [7:0] a;
    void'($urandom(32'h5eed_c0de));
    model_reset();
    do_reset();

    // R4: idle traffic without a start is echoed and ignored
    upd(0, 0, "R4"); chk("R4", {7'd0, sda_out}, 8'd0);
    upd(1, 0, "R4"); chk("R4", {7'd0, sda_out}, 8'd0);
    upd(0, 1, "R4"); chk("R4", {7'd0, sda_out}, 8'd1);
    upd(1, 1, "R4"); chk("R4", {7'd0, sda_out}, 8'd1);
    upd(0, 0, "R4"); upd(1, 1, "R4"); chk("R4", {7'd0, sda_out}, 8'd1);

    // R8/R10: reads shift out the byte fetched by the previous transaction
    txn(1, 8'h00, seen); chk("R8", seen, 8'h00);
    txn(1, 8'h01, seen); chk("R10", seen, 8'h80);
    txn(0, 8'h02, seen); chk("R6", seen, 8'h02);
    txn(1, 8'h05, seen); chk("R10", seen, 8'h04);
    txn(1, 8'hFF, seen); chk("R10", seen, 8'h26);
    txn(1, 8'h00, seen); chk("R10", seen, 8'hFC);
    txn(1, 8'h10, seen); chk("R10", seen, 8'h80);

    // R3: stop inside the command does not restart the count
    start_cond();
    upd(0, 1, "R3"); upd(1, 1, "R3");
    upd(0, 0, "R3"); upd(1, 0, "R3");
    upd(0, 1, "R3"); upd(1, 1, "R3");
    upd(0, 0, "R3"); upd(1, 0, "R3");                    // 4th bit
    upd(1, 1, "R3");                                     // stop
    upd(0, 1, "R3"); upd(1, 1, "R3");
    upd(0, 1, "R3"); upd(1, 1, "R3");
    upd(0, 0, "R3"); upd(1, 0, "R3");
    upd(0, 1, "R3"); upd(1, 1, "R3");                    // 8th bit
    ack_clk("R3");
    send_byte(8'h03, "R8");
    ack_clk("R9");
    upd(0, 1, "R9"); upd(1, 1, "R9");
    chk("R8", {7'd0, sda_out}, 8'd1);                    // back to idle

    // R5: a rising update that changes SDA takes no bit
    start_cond();
    upd(0, 1, "R5"); upd(1, 1, "R5");
    upd(0, 1, "R5"); upd(1, 1, "R5");
    upd(0, 0, "R5"); upd(1, 0, "R5");
    upd(0, 0, "R5"); upd(1, 1, "R5");                    // glitch
    chk("R5", {7'd0, sda_out}, 8'd1);
    for (int i = 0; i < 5; i++) begin
      upd(0, 1, "R5"); upd(1, 1, "R5");
    end
    chk("R5", {7'd0, sda_out}, 8'd1);                    // 8th taken bit, not ack
    ack_clk("R5");
    send_byte(8'h07, "R8");
    ack_clk("R9");

    // R2: a restart mid-command clears the count
    start_cond();
    send_byte(8'h0F, "R2");                              // 8 bits, ack pending
    upd(0, 1, "R2"); upd(1, 1, "R2");                    // consumes the ack
    chk("R7", {7'd0, sda_out}, 8'd0);
    upd(1, 1, "R2");
    start_cond();
    for (int i = 0; i < 4; i++) begin
      upd(0, 1, "R2"); upd(1, 1, "R2");
    end
    upd(1, 0, "R2");                                     // restart
    for (int i = 0; i < 7; i++) begin
      upd(0, 1, "R2"); upd(1, 1, "R2");
    end
    chk("R2", {7'd0, sda_out}, 8'd1);                    // 7 bits: no ack yet
    upd(0, 1, "R2"); upd(1, 1, "R2");
    ack_clk("R2");
    send_byte(8'h02, "R8");
    ack_clk("R9");

    // Random traffic against the reference
    for (int n = 0; n < 2500; n++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0) begin
        upd(1'($urandom), 1'($urandom), "R12");
      end else if (r == 1) begin
        upd(1, 1, "R12"); upd(1, 0, "R12");
      end else begin
        bit b;
        b = 1'($urandom);
        upd(0, b, "R12"); upd(1, b, "R12");
      end
    end

    // Reset from an arbitrary state, then a known read
    do_reset();
    a = 8'($urandom);
    txn(1, 8'h02, seen);
    txn(1, a, seen); chk("R10", seen, 8'h04);
    txn(1, 8'h00, seen); chk("R10", seen, rom_ref(a));

    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule